// File: doc/BRIEF.md
# Two-Phase Clocked Delay Cell

This block models a dynamic delay stage that runs from a two-phase, non-overlapping clock. The whole design sits in one fast system clock domain. The two phases arrive as level enables sampled on that clock. While phase 1 is high, the stage captures a value into an internal storage node. While phase 2 is high, it moves the stored value to a registered output and also drives a registered complement of that output. An input therefore needs one phase-1 interval followed by one phase-2 interval to reach the output.

A parameter fixes the stage variant:
- a plain one-input delay;
- a two-input OR delay;
- a delay with a stage clear that holds the output low;
- a sticky variant that feeds its own output back into the captured value.

Two sticky error flags report misuse of the phases. The first flags both phases high at once. The second flags a storage node held too long between the end of phase 1 and the start of phase 2, which models charge lost from the dynamic node.

Top module: `biphase_delay_cell`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the cell clears itself: after that edge `q` is 0, `q_n` is 1, and both error flags are 0.
- R2: The value is captured on every clock where `ph1_en`=1 and `ph2_en`=0. During those cycles `q` does not change unless a stage clear applies. `q` takes the stored value only after a clock where `ph2_en`=1 and `ph1_en`=0. A phase-1 interval alone never moves the input to `q`.
- R3: `q_n` is always the inverse of `q`.
- R4: With MODE=BPD_OR2, the captured value is `in_a | in_b`.
- R5: With MODE=BPD_CLEAR, any clock where `clr`=1 forces `q` low after that edge and clears the storage node, whatever the phases. With `clr`=0, the cell behaves like the one-input delay.
- R6: With MODE=BPD_STICKY, the captured value is `in_a | q`. Once a 1 has reached `q`, later phase sequences that capture `in_a`=0 leave `q` at 1.
- R7: With MODE=BPD_STICKY, `q` is cleared only when `clr`=1 throughout phase 1. Asserting `clr` outside phase 1 has no effect. The cleared value appears on `q` only after the following phase-2 clock.
- R8: A hold counter starts on the first clock where `ph1_en` is low after being high. Call G the number of consecutive clocks with both phases low, counted from that clock. If G is at most HOLD_MAX, the captured value transfers intact. If G exceeds HOLD_MAX, the node is forced to 1, the next transfer delivers 1, and `err_hold_lost` is set and stays set until `rst_n`.
- R9: A clock with `ph1_en`=1 and `ph2_en`=1 sets `err_overlap`, which stays set until `rst_n`. In that clock neither a capture nor a transfer takes place.
- R10: With MODE=BPD_SINGLE, the captured value is `in_a`, and `in_b` has no effect on `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ph1_en | input | 1 | Phase-1 (capture) enable, level |
| ph2_en | input | 1 | Phase-2 (transfer) enable, level |
| in_a | input | 1 | Primary data input |
| in_b | input | 1 | Second data input (OR mode only) |
| clr | input | 1 | Stage clear (clear and sticky modes) |
| q | output | 1 | Registered delayed output |
| q_n | output | 1 | Registered complement of `q` |
| err_overlap | output | 1 | Sticky flag: both phases were high together |
| err_hold_lost | output | 1 | Sticky flag: the storage node outlived its hold limit |

## Verification
The bench places the hold gap exactly at HOLD_MAX and then one clock beyond it. An off-by-one counter would either corrupt a legal transfer or let a stale value through without raising the flag. It sends an overlap clock carrying different input data and then a lone phase-2 clock. A design that captured or transferred during the overlap would show the wrong value on `q`. In sticky mode it pulses the clear outside phase 1 and then inside phase 1, and it reads `q` before and after the next phase 2. A design that cleared the output immediately, or accepted a clear without phase 1, would differ there. It also drives `in_b` high on the one-input variant, where a leaking OR would show up on `q`.

// File: rtl/bpd_pkg.sv
// Package: shared types for the two-phase delay cell.
// Assumes: nothing; pure type definitions.
package bpd_pkg;

    // Variant selector for the delay stage.
    typedef enum logic [1:0] {
        BPD_SINGLE = 2'd0,
        BPD_OR2    = 2'd1,
        BPD_CLEAR  = 2'd2,
        BPD_STICKY = 2'd3
    } bpd_mode_e;

endpackage

// File: rtl/bpd_phase_tracker.sv
// Module: bpd_phase_tracker
// Decodes the two phase enables into capture and transfer strobes.
// Flags overlapping phases, and times the gap between the fall of phase 1
// and the rise of phase 2.
// Assumes: both enables are synchronous to clk; HOLD_MAX >= 1.
module bpd_phase_tracker #(
    parameter int HOLD_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ph1_en,
    input  logic ph2_en,
    output logic cap_en,
    output logic xfer_en,
    output logic hold_expire,
    output logic err_overlap
);
    localparam int CNT_W = $clog2(HOLD_MAX + 1);

    logic             ph1_q;
    logic             waiting;
    logic [CNT_W-1:0] gap_cnt;
    logic             ph1_fall;

    // Purpose: strobes for capture, transfer, phase-1 fall and node expiry.
    always_comb begin
        cap_en      = ph1_en & ~ph2_en;
        xfer_en     = ph2_en & ~ph1_en;
        ph1_fall    = ph1_q & ~ph1_en;
        hold_expire = waiting & ~ph1_en & ~ph2_en
                      & (gap_cnt == CNT_W'(HOLD_MAX));
    end

    // Purpose: remember phase 1 and run the inter-phase hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph1_q   <= 1'b0;
            waiting <= 1'b0;
            gap_cnt <= '0;
        end else begin
            ph1_q <= ph1_en;
            if (ph1_fall && !ph2_en) begin
                waiting <= 1'b1;
                gap_cnt <= CNT_W'(1);
            end else if (ph1_en || ph2_en || hold_expire) begin
                waiting <= 1'b0;
            end else if (waiting) begin
                gap_cnt <= gap_cnt + CNT_W'(1);
            end
        end
    end

    // Purpose: sticky flag for both phases high in one clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_overlap <= 1'b0;
        else if (ph1_en && ph2_en)
            err_overlap <= 1'b1;
    end

endmodule

// File: rtl/bpd_input_gate.sv
// Module: bpd_input_gate
// Forms the value to capture for the selected variant. Also raises the
// force-low request that the clear variant uses.
// Assumes: fb is the registered stage output.
module bpd_input_gate
    import bpd_pkg::*;
#(
    parameter bpd_mode_e MODE = BPD_SINGLE
) (
    input  logic in_a,
    input  logic in_b,
    input  logic clr,
    input  logic fb,
    output logic nxt,
    output logic force_low
);
    // Purpose: choose the capture expression and clear behaviour per variant.
    always_comb begin
        nxt       = in_a;
        force_low = 1'b0;
        case (MODE)
            BPD_SINGLE: nxt = in_a;
            BPD_OR2:    nxt = in_a | in_b;
            BPD_CLEAR: begin
                nxt       = in_a & ~clr;
                force_low = clr;
            end
            BPD_STICKY: nxt = (in_a | fb) & ~clr;
            default:    nxt = in_a;
        endcase
    end

endmodule

// File: rtl/bpd_output_stage.sv
// Module: bpd_output_stage
// Holds the storage node, the registered true and complement outputs, and
// the sticky hold-lost flag.
// Assumes: cap_en and xfer_en are never high together.
module bpd_output_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic xfer_en,
    input  logic hold_expire,
    input  logic force_low,
    input  logic nxt,
    output logic q,
    output logic q_n,
    output logic err_hold_lost
);
    logic node;

    // Purpose: storage node capture, forced clear, and float-high on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            node <= 1'b0;
        else if (force_low)
            node <= 1'b0;
        else if (cap_en)
            node <= nxt;
        else if (hold_expire)
            node <= 1'b1;
    end

    // Purpose: transfer the node to the two output flops in phase 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= 1'b0;
            q_n <= 1'b1;
        end else if (force_low) begin
            q   <= 1'b0;
            q_n <= 1'b1;
        end else if (xfer_en) begin
            q   <= node;
            q_n <= ~node;
        end
    end

    // Purpose: sticky record that the node outlived its hold limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_hold_lost <= 1'b0;
        else if (hold_expire)
            err_hold_lost <= 1'b1;
    end

endmodule

// File: rtl/biphase_delay_cell.sv
// Module: biphase_delay_cell (top)
// A two-phase dynamic delay stage emulated on one system clock. It
// captures during phase 1, transfers during phase 2, and checks for
// overlap and over-long hold.
// Assumes: all inputs are synchronous to clk; HOLD_MAX >= 1.
module biphase_delay_cell
    import bpd_pkg::*;
#(
    parameter bpd_mode_e MODE     = BPD_SINGLE,
    parameter int        HOLD_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ph1_en,
    input  logic ph2_en,
    input  logic in_a,
    input  logic in_b,
    input  logic clr,
    output logic q,
    output logic q_n,
    output logic err_overlap,
    output logic err_hold_lost
);
    logic cap_en;
    logic xfer_en;
    logic hold_expire;
    logic nxt;
    logic force_low;

    bpd_phase_tracker #(.HOLD_MAX(HOLD_MAX)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .ph1_en      (ph1_en),
        .ph2_en      (ph2_en),
        .cap_en      (cap_en),
        .xfer_en     (xfer_en),
        .hold_expire (hold_expire),
        .err_overlap (err_overlap)
    );

    bpd_input_gate #(.MODE(MODE)) u_gate (
        .in_a      (in_a),
        .in_b      (in_b),
        .clr       (clr),
        .fb        (q),
        .nxt       (nxt),
        .force_low (force_low)
    );

    bpd_output_stage u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .cap_en        (cap_en),
        .xfer_en       (xfer_en),
        .hold_expire   (hold_expire),
        .force_low     (force_low),
        .nxt           (nxt),
        .q             (q),
        .q_n           (q_n),
        .err_hold_lost (err_hold_lost)
    );

endmodule

// File: rtl/bpd_checks.sv
// Module: bpd_checks
// Property checker bound to every biphase_delay_cell instance.
// Assumes: it is connected to the top-level ports only.
module bpd_checks
    import bpd_pkg::*;
#(
    parameter bpd_mode_e MODE = BPD_SINGLE
) (
    input logic clk,
    input logic rst_n,
    input logic ph1_en,
    input logic ph2_en,
    input logic clr,
    input logic q,
    input logic q_n,
    input logic err_overlap,
    input logic err_hold_lost
);
    // R1: reset clears the outputs and both flags.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!q && q_n && !err_overlap && !err_hold_lost));

    // R3: the two output flops always disagree.
    a_r3_complement: assert property (@(posedge clk) disable iff (!rst_n)
        q_n == !q);

    // R2: a phase-1-only clock without a clear leaves q alone.
    a_r2_quiet_in_ph1: assert property (@(posedge clk) disable iff (!rst_n)
        (ph1_en && !ph2_en && !clr) |=> $stable(q));

    // R9: an overlap clock raises the flag and moves nothing.
    a_r9_overlap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ph1_en && ph2_en) |=> err_overlap);

    a_r9_overlap_no_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (ph1_en && ph2_en && !clr) |=> $stable(q));

    a_r9_overlap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_overlap |=> err_overlap);

    // R8: the hold-lost flag never drops without reset.
    a_r8_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_hold_lost |=> err_hold_lost);

    // R5: the clear variant drives q low after any clear clock.
    generate
        if (MODE == BPD_CLEAR) begin : g_clear_chk
            a_r5_clear_forces_low: assert property (@(posedge clk)
                disable iff (!rst_n) clr |=> (!q && q_n));
        end
    endgenerate

endmodule

bind biphase_delay_cell bpd_checks #(.MODE(MODE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ph1_en        (ph1_en),
    .ph2_en        (ph2_en),
    .clr           (clr),
    .q             (q),
    .q_n           (q_n),
    .err_overlap   (err_overlap),
    .err_hold_lost (err_hold_lost)
);

// File: tb/biphase_delay_cell_tb.sv
module biphase_delay_cell_tb;
    import bpd_pkg::*;

    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ph1 = 1'b0, ph2 = 1'b0, a = 1'b0, b = 1'b0, c = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    logic la_q, la_n, la_ov, la_hl;
    logic so_q, so_n, so_ov, so_hl;
    logic or_q, or_n, or_ov, or_hl;
    logic rs_q, rs_n, rs_ov, rs_hl;

    always #4 clk = ~clk;

    biphase_delay_cell #(.MODE(BPD_STICKY), .HOLD_MAX(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .ph1_en(ph1), .ph2_en(ph2),
        .in_a(a), .in_b(b), .clr(c),
        .q(la_q), .q_n(la_n), .err_overlap(la_ov), .err_hold_lost(la_hl));
    biphase_delay_cell #(.MODE(BPD_SINGLE), .HOLD_MAX(HOLD)) u_dut_single (
        .clk(clk), .rst_n(rst_n), .ph1_en(ph1), .ph2_en(ph2),
        .in_a(a), .in_b(b), .clr(c),
        .q(so_q), .q_n(so_n), .err_overlap(so_ov), .err_hold_lost(so_hl));
    biphase_delay_cell #(.MODE(BPD_OR2), .HOLD_MAX(HOLD)) u_dut_or (
        .clk(clk), .rst_n(rst_n), .ph1_en(ph1), .ph2_en(ph2),
        .in_a(a), .in_b(b), .clr(c),
        .q(or_q), .q_n(or_n), .err_overlap(or_ov), .err_hold_lost(or_hl));
    biphase_delay_cell #(.MODE(BPD_CLEAR), .HOLD_MAX(HOLD)) u_dut_clr (
        .clk(clk), .rst_n(rst_n), .ph1_en(ph1), .ph2_en(ph2),
        .in_a(a), .in_b(b), .clr(c),
        .q(rs_q), .q_n(rs_n), .err_overlap(rs_ov), .err_hold_lost(rs_hl));

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, then sample 1 ns after the rising edge.
    task automatic step(input logic p1, input logic p2, input logic ia,
                        input logic ib, input logic ic);
        @(negedge clk);
        ph1 = p1; ph2 = p2; a = ia; b = ib; c = ic;
        @(posedge clk);
        #1;
    endtask

    // Full sequence: 2 phase-1 clocks, gap idle clocks, 2 phase-2 clocks, 1 idle clock.
    task automatic seq(input logic ia, input logic ib, input logic ic, input int gap);
        step(1, 0, ia, ib, ic);
        step(1, 0, ia, ib, ic);
        for (int i = 0; i < gap; i++) step(0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 sticky q", la_q, 0);   chk("R1 sticky q_n", la_n, 1);
        chk("R1 single q", so_q, 0);   chk("R1 or q", or_q, 0);
        chk("R1 clear q", rs_q, 0);    chk("R1 overlap flag", so_ov, 0);
        chk("R1 hold flag", so_hl, 0);
    endtask

    task automatic t_basic();
        do_reset();
        step(1, 0, 1, 0, 0);
        chk("R2 no change in ph1", so_q, 0);
        step(1, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        chk("R2 no change before ph2", so_q, 0);
        step(0, 1, 0, 0, 0);
        chk("R2 transfer in ph2", so_q, 1);
        chk("R3 complement", so_n, 0);
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        seq(0, 1, 0, 1);
        chk("R10 in_b ignored", so_q, 0);
        chk("R4 or via in_b", or_q, 1);
        chk("R3 or complement", or_n, 0);
        seq(0, 0, 0, 1);
        chk("R4 or both low", or_q, 0);
        seq(1, 0, 0, 1);
        chk("R4 or via in_a", or_q, 1);
    endtask

    task automatic t_clear_mode();
        do_reset();
        seq(1, 0, 0, 1);
        chk("R5 acts as delay", rs_q, 1);
        step(0, 0, 0, 0, 1);
        chk("R5 clear forces low", rs_q, 0);
        chk("R5 clear complement", rs_n, 1);
        step(1, 0, 1, 0, 1);
        step(1, 0, 1, 0, 1);
        step(0, 0, 0, 0, 1);
        step(0, 1, 0, 0, 1);
        chk("R5 held low in ph2", rs_q, 0);
        step(0, 1, 0, 0, 0);
        chk("R5 node cleared", rs_q, 0);
        step(0, 0, 0, 0, 0);
        seq(1, 0, 0, 1);
        chk("R5 delay after release", rs_q, 1);
    endtask

    task automatic t_sticky();
        do_reset();
        seq(1, 0, 0, 1);
        chk("R6 first high", la_q, 1);
        seq(0, 0, 0, 1);
        chk("R6 stays high", la_q, 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        seq(0, 0, 0, 1);
        chk("R7 clear outside ph1 ignored", la_q, 1);
        step(1, 0, 0, 0, 1);
        step(1, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        chk("R7 not cleared before ph2", la_q, 1);
        step(0, 1, 0, 0, 0);
        chk("R7 cleared at ph2", la_q, 0);
        chk("R7 complement", la_n, 1);
        step(0, 0, 0, 0, 0);
        seq(0, 0, 0, 1);
        chk("R7 stays cleared", la_q, 0);
    endtask

    task automatic t_hold();
        do_reset();
        seq(0, 0, 0, HOLD);
        chk("R8 gap at limit value", so_q, 0);
        chk("R8 gap at limit flag", so_hl, 0);
        seq(0, 0, 0, HOLD + 1);
        chk("R8 gap over limit value", so_q, 1);
        chk("R8 gap over limit flag", so_hl, 1);
        seq(0, 0, 0, 1);
        chk("R8 recovers value", so_q, 0);
        chk("R8 flag sticky", so_hl, 1);
    endtask

    task automatic t_overlap();
        do_reset();
        step(1, 0, 1, 0, 0);
        step(1, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        chk("R9 no transfer", so_q, 0);
        chk("R9 flag set", so_ov, 1);
        step(0, 1, 0, 0, 0);
        chk("R9 no capture", so_q, 1);
        step(0, 0, 0, 0, 0);
        chk("R9 flag sticky", so_ov, 1);
        chk("R9 no hold error", so_hl, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_basic();
        t_clear_mode();
        t_sticky();
        t_hold();
        t_overlap();
        finish_run();
    end

endmodule